// File: doc/BRIEF.md
# Serial-to-Register Bus Bridge

This block is a serial slave that works entirely in the system clock domain. It converts framed transfers from a four-wire serial master into single-byte accesses on a plain parallel register bus. The serial clock, the select and the data input are brought in through flop synchronizers. Clock edges are then found by oversampling, so the serial bit period must span several system clocks.

A frame is a 16-bit header followed by one 8-bit data byte, both most significant bit first. The top header bit selects the direction, with 1 for a write and 0 for a read. The other fifteen header bits are the register address.

- In a write frame, the byte is put on the bus once all of its bits are in.
- In a read frame, the bus is read as soon as the header is complete. The returned byte then goes out on the serial output in the bit periods that follow at once, with no gap bits.

Top module: `spi_reg_bridge`

## Requirements
- R1: After reset, `bus_we`, `bus_re` and `spi_miso` are all low.
- R2: The 16 header bits are taken MSB first on rising serial clock edges. Header bit 15 is the direction flag (1 = write, 0 = read). Header bits 14..0 appear on `bus_addr` for the bus access.
- R3: A write frame (flag 1) gives exactly one `bus_we` pulse of one system clock. It comes only after the 24th bit has been taken, and `bus_wdata` then holds the 8 data bits received MSB first.
- R4: A read frame (flag 0) gives exactly one `bus_re` pulse of one system clock, right after the 16th bit. `bus_rdata` is taken two system clocks after `bus_re` rises.
- R5: In a read frame, the returned byte is driven on `spi_miso` MSB first in bit periods 16..23. Each bit is updated on a falling serial clock edge and is stable at the rising edge in the middle of its period.
- R6: `spi_miso` stays low while select is high, during the header, and for the whole of a write frame.
- R7: Raising select before 24 bits have arrived ends the frame with no write, and the next frame is decoded from its first bit.
- R8: A read frame causes no `bus_we`, and a write frame causes no `bus_re`.
- R9: Serial clock edges while select is high have no effect on the next frame.
- R10: Bits beyond the 24th in one select period are ignored and cause no further bus access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| bus_addr | output | ADDR_W-1 | Register address (15 bits by default) |
| bus_wdata | output | DATA_W | Write data |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| bus_rdata | input | DATA_W | Read data, valid two clocks after `bus_re` |

## Verification
The bench uses the default parameters: a 16-bit header, an 8-bit data field and two synchronizer stages. It drives a bit period of 8 system clocks, which is the tightest ratio the bridge must meet. At that ratio the three-clock input delay, the two-clock bus answer and the falling-edge update of the output byte all have to fit inside half a bit period.

The bench's bus model returns data only one clock after it sees `bus_re`, so a bridge that samples too early reads a wrong byte. The bench also runs frames at both ends of the address range, aborted and over-long frames, and clock activity while select is high.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

    // synchronized pin levels
    typedef struct packed {
        logic sck;
        logic cs_n;
        logic mosi;
    } spi_pins_t;

    // events derived from the oversampled pins
    typedef struct packed {
        logic active;   // select low
        logic rise;     // serial clock rising, select low
        logic fall;     // serial clock falling, select low
        logic cs_rise;  // select released
        logic mosi;     // synchronized data level
    } spi_evt_t;

    function automatic logic hdr_is_write(input logic flag);
        return flag;
    endfunction

endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync
    import spi_bridge_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  spi_pins_t pins,
    output spi_evt_t  evt
);
    localparam int PW = $bits(spi_pins_t);

    logic [PW-1:0] stg [STAGES];
    spi_pins_t     cur, prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[i] <= PW'(3'b010);
                end else if (i == 0) begin
                    stg[i] <= pins;
                end else begin
                    stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign cur = spi_pins_t'(stg[STAGES-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '{sck: 1'b0, cs_n: 1'b1, mosi: 1'b0};
        end else begin
            prev <= cur;
        end
    end

    always_comb begin
        evt.active  = !cur.cs_n;
        evt.rise    = !cur.cs_n && cur.sck && !prev.sck;
        evt.fall    = !cur.cs_n && !cur.sck && prev.sck;
        evt.cs_rise = cur.cs_n && !prev.cs_n;
        evt.mosi    = cur.mosi;
    end

endmodule

// File: rtl/spi_bridge_frame.sv
module spi_bridge_frame
    import spi_bridge_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  spi_evt_t          evt,
    output logic              miso,
    output logic [ADDR_W-2:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] HDR_DONE   = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FRAME_END  = CNT_W'(FRAME_W);

    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] rx_sr;
    logic               wr_dir;
    logic [1:0]         rd_wait;
    logic [DATA_W-1:0]  tx_sr;
    logic               tx_on;
    logic               take;
    logic               out_phase;

    assign take      = evt.rise && (bit_cnt != FRAME_END);
    assign out_phase = !wr_dir && (bit_cnt >= HDR_DONE) && (bit_cnt < FRAME_END);

    always_ff @(posedge clk) begin
        bus_we <= 1'b0;
        bus_re <= 1'b0;
        if (rst) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            wr_dir    <= 1'b1;
            rd_wait   <= '0;
            tx_sr     <= '0;
            tx_on     <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (evt.cs_rise) begin
            bit_cnt <= '0;
            wr_dir  <= 1'b1;
            rd_wait <= '0;
            tx_on   <= 1'b0;
        end else begin
            if (take) begin
                rx_sr   <= {rx_sr[FRAME_W-2:0], evt.mosi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == HDR_LAST) begin
                    bus_addr <= {rx_sr[ADDR_W-3:0], evt.mosi};
                    wr_dir   <= hdr_is_write(rx_sr[ADDR_W-2]);
                    if (!hdr_is_write(rx_sr[ADDR_W-2])) begin
                        bus_re  <= 1'b1;
                        rd_wait <= 2'd2;
                    end
                end
                if (bit_cnt == FRAME_LAST && wr_dir) begin
                    bus_we    <= 1'b1;
                    bus_wdata <= {rx_sr[DATA_W-2:0], evt.mosi};
                end
            end
            if (rd_wait != 2'd0) begin
                rd_wait <= rd_wait - 2'd1;
                if (rd_wait == 2'd1) begin
                    tx_sr <= bus_rdata;
                end
            end
            if (evt.fall && out_phase) begin
                if (!tx_on) begin
                    tx_on <= 1'b1;
                end else begin
                    tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso = evt.active && tx_on && tx_sr[DATA_W-1];

    // R3
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> !bus_we);
    // R4
    re_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bus_re |=> !bus_re);
    // R8
    we_re_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_re));
    // R6
    miso_dir_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_on) |-> !wr_dir);
    // R7
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        evt.cs_rise |=> !bus_we && !tx_on);

endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
    import spi_bridge_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-2:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata
);
    spi_pins_t pins;
    spi_evt_t  evt;

    assign pins = '{sck: spi_sck, cs_n: spi_cs_n, mosi: spi_mosi};

    spi_bridge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pins (pins),
        .evt  (evt)
    );

    spi_bridge_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .miso      (spi_miso),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata)
    );

    // R1
    miso_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> !spi_miso);

endmodule

// File: tb/sim_spi_reg_bridge.sv
module sim_spi_reg_bridge;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [14:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic bus_we, bus_re;

    int checks = 0, fails = 0;
    int we_cnt = 0, re_cnt = 0;
    logic [14:0] last_wa, last_ra;
    logic [7:0]  last_wd;
    logic        re_d = 1'b0;
    logic [14:0] addr_d = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    spi_reg_bridge u0 (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] reg_val(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
    endfunction

    // bus model: answers one clock after the strobe, junk before
    initial bus_rdata = 8'hEE;
    always @(negedge clk) begin
        if (re_d) bus_rdata = reg_val(addr_d);
        else if (!bus_re) bus_rdata = 8'hEE;
        re_d   = bus_re;
        addr_d = bus_addr;
        if (bus_we) begin we_cnt++; last_wa = bus_addr; last_wd = bus_wdata; end
        if (bus_re) begin re_cnt++; last_ra = bus_addr; end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [15:0] hdr, input logic [7:0] wd, input int nbits,
                         output logic [7:0] rd, output int miso_hi);
        logic [23:0] fr;
        fr = {hdr, wd};
        rd = '0;
        miso_hi = 0;
        @(negedge clk) cs_n = 1'b0;
        for (int b = 0; b < nbits; b++) begin
            mosi = (b < 24) ? fr[23-b] : 1'b1;
            sck  = 1'b0;
            repeat (4) begin
                @(negedge clk);
                if ((b < 16 || hdr[15]) && miso) miso_hi++;
            end
            if (b >= 16 && b < 24) rd[23-b] = miso;
            sck = 1'b1;
            repeat (4) @(negedge clk);
        end
        sck = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 we", bus_we, 0);
        chk("R1 re", bus_re, 0);
        chk("R1 miso", miso, 0);
    endtask

    task automatic t_write(input logic [14:0] a, input logic [7:0] d);
        int w0, r0, hi; logic [7:0] rd;
        w0 = we_cnt; r0 = re_cnt;
        frame({1'b1, a}, d, 24, rd, hi);
        chk("R3 one write", we_cnt, w0 + 1);
        chk("R2 write addr", last_wa, a);
        chk("R3 write data", last_wd, d);
        chk("R8 no read in write", re_cnt, r0);
        chk("R6 miso low in write", hi, 0);
    endtask

    task automatic t_read(input logic [14:0] a);
        int w0, r0, hi; logic [7:0] rd;
        w0 = we_cnt; r0 = re_cnt;
        frame({1'b0, a}, 8'hFF, 24, rd, hi);
        chk("R4 one read", re_cnt, r0 + 1);
        chk("R2 read addr", last_ra, a);
        chk("R5 miso byte", rd, reg_val(a));
        chk("R8 no write in read", we_cnt, w0);
        chk("R6 miso low in header", hi, 0);
        chk("R6 miso low after", miso, 0);
    endtask

    task automatic t_abort;
        int w0, hi; logic [7:0] rd;
        w0 = we_cnt;
        frame({1'b1, 15'h1234}, 8'h77, 20, rd, hi);
        chk("R7 aborted no write", we_cnt, w0);
        t_write(15'h0456, 8'hC3);   // R7 next frame clean
    endtask

    task automatic t_idle_sck;
        int w0;
        w0 = we_cnt;
        mosi = 1'b1;
        for (int i = 0; i < 30; i++) begin
            sck = 1'b1; repeat (4) @(negedge clk);
            sck = 1'b0; repeat (4) @(negedge clk);
            if (miso) chk("R6 miso idle", miso, 0);
        end
        mosi = 1'b0;
        chk("R9 idle clocks no access", we_cnt, w0);
        t_write(15'h0003, 8'hA5);   // R9
    endtask

    task automatic t_extra;
        int w0, r0, hi; logic [7:0] rd;
        w0 = we_cnt; r0 = re_cnt;
        frame({1'b1, 15'h0BEE}, 8'h81, 32, rd, hi);
        chk("R10 single write", we_cnt, w0 + 1);
        chk("R10 data kept", last_wd, 8'h81);
        chk("R10 no read", re_cnt, r0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write(15'h0000, 8'h5A);
        t_write(15'h7FFF, 8'hA5);
        t_read(15'h0000);
        t_read(15'h7FFF);
        t_read(15'h2A51);
        t_abort();
        t_idle_sck();
        t_extra();
        t_read(15'h0001);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule